// File: doc/BRIEF.md
# CMAC Response Accumulator and Trainer

This block sits between a CMAC associative mapper and a single-port weight RAM. The mapper supplies a stream of weight addresses, one for each excited receptive field. Each RAM word holds one signed 8-bit weight for each of eight output channels, one byte lane per channel. A start pulse clears the channel sums and selects one of two modes for the pass that follows.

In recall mode, the block reads the word at each address and adds every lane, sign-extended, into that channel's 16-bit signed sum. The sum saturates at its limits. In training mode, the block reads the word and adds a signed per-channel adjustment to each lane, saturating to the 8-bit range. It writes the result back to the same address two cycles after the read. The address stream is stalled while a training update is in flight. The address flagged as last ends the pass, and a done flag then stays high until the next start.

Top module: `cmac_accum`

## Requirements
- R1: While reset is low and after its release, before any start, all sums read zero, done is low, address ready is low and neither RAM strobe is raised.
- R2: A start pulse sets every sum to zero, clears done and latches the mode (train_i high selects training). It drops any read or write still in flight, and no address is accepted in the start cycle. From the next cycle the block accepts addresses.
- R3: In recall mode an accepted address (valid and ready high) raises ram_re_o in the same cycle with ram_addr_o equal to the address. The RAM returns the word one cycle later, and its lane k (bits 8k+7..8k, signed) is added into sum k (sum_o bits 16k+15..16k) at the end of that cycle.
- R4: A channel sum that would pass +32767 or -32768 stays at that limit.
- R5: In training mode the read word's lane k is added to adj_i lane k (bits 8k+7..8k, signed, sampled in the cycle the read data returns). The result is written with ram_we_o to the same address in the cycle after the data returns.
- R6: A trained weight that would pass +127 or -128 is written as that limit.
- R7: In training mode address ready is low from the cycle after an accept through its write cycle, so at most one address is taken every three cycles. The channel sums do not change in training mode.
- R8: done_o rises in the cycle after the last address's read data returns in recall mode, or in the cycle after its write in training mode. It then stays high until a start.
- R9: Before the first start, and after the last-flagged address has been accepted, addresses are not accepted: ready stays low and no RAM access is made.
- R10: ram_re_o and ram_we_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears sums and done, begins a pass |
| train_i | input | 1 | Mode sampled on start: 1 training, 0 recall |
| adj_i | input | 64 | Signed per-channel weight adjustments, 8 bits per lane |
| addr_valid_i | input | 1 | Address stream valid |
| addr_i | input | 18 | Weight address |
| last_i | input | 1 | Marks the final address of the pass |
| addr_ready_o | output | 1 | Address accepted when high together with valid |
| ram_re_o | output | 1 | RAM read strobe |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | 18 | RAM address for read or write |
| ram_wdata_o | output | 64 | Updated weights, one byte lane per channel |
| ram_rdata_i | input | 64 | Read data, valid one cycle after ram_re_o |
| sum_o | output | 128 | Signed channel sums, 16 bits per channel |
| done_o | output | 1 | Pass complete, held until next start |

## Verification
The bench drives one address for 300 cycles with lanes at +127 and -128. A design that wrapped the sum would show a sign flip instead of sums pinned at +32767 and -32768. Training passes push weights past both 8-bit limits and hit the same address twice. A design without the stall, or with the wrong write timing, would write a stale value or lose the first update. A start issued while a training read is in flight must leave the stored weight untouched. Addresses offered before a start and after the last one must cause no RAM access, and a done that rose a cycle early or late is flagged by the per-cycle comparison.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
  localparam int unsigned CH_N = 8;
  localparam int unsigned WGT_W = 8;
  localparam int unsigned SUM_W = 16;
  localparam int unsigned ADR_W = 18;

  typedef enum logic {
    MODE_RECALL = 1'b0,
    MODE_TRAIN  = 1'b1
  } mode_e;
endpackage

// File: rtl/cmac_ctrl.sv
module cmac_ctrl
  import cmac_pkg::*;
#(
  parameter int unsigned A_W = ADR_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           train_i,
  input  logic           addr_valid_i,
  input  logic [A_W-1:0] addr_i,
  input  logic           last_i,
  output logic           addr_ready_o,
  output logic           ram_re_o,
  output logic           ram_we_o,
  output logic [A_W-1:0] ram_addr_o,
  output logic           done_o,
  output logic           clr_o,
  output logic           acc_en_o,
  output logic           upd_en_o
);
  mode_e          mode_q;
  logic           active_q, done_q;
  logic           pend_q, pend_last_q;
  logic [A_W-1:0] pend_addr_q;
  logic           wr_q, wr_last_q;
  logic [A_W-1:0] wr_addr_q;
  logic           accept;

  // training serialises read, data return and write-back
  assign addr_ready_o = active_q && !start_i
                        && !((mode_q == MODE_TRAIN) && (pend_q || wr_q));
  assign accept       = addr_valid_i && addr_ready_o;
  assign ram_re_o     = accept;
  assign ram_we_o     = wr_q;
  assign ram_addr_o   = wr_q ? wr_addr_q : addr_i;
  assign done_o       = done_q;
  assign clr_o        = start_i;
  assign acc_en_o     = pend_q && (mode_q == MODE_RECALL) && !start_i;
  assign upd_en_o     = pend_q && (mode_q == MODE_TRAIN) && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_RECALL;
      active_q    <= 1'b0;
      done_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_last_q <= 1'b0;
      pend_addr_q <= '0;
      wr_q        <= 1'b0;
      wr_last_q   <= 1'b0;
      wr_addr_q   <= '0;
    end else if (start_i) begin
      mode_q   <= train_i ? MODE_TRAIN : MODE_RECALL;
      active_q <= 1'b1;
      done_q   <= 1'b0;
      pend_q   <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      pend_q      <= accept;
      pend_last_q <= accept && last_i;
      if (accept) pend_addr_q <= addr_i;
      wr_q        <= upd_en_o;
      wr_last_q   <= pend_last_q;
      wr_addr_q   <= pend_addr_q;
      if (accept && last_i) active_q <= 1'b0;
      if ((acc_en_o && pend_last_q) || (wr_q && wr_last_q)) done_q <= 1'b1;
    end
  end

  AST_PORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_re_o && ram_we_o)); // R10
  AST_WB_SAME_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ($past(ram_re_o, 2) && ram_addr_o == $past(ram_addr_o, 2))); // R5
  AST_WR_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> !addr_ready_o); // R7
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R8
  AST_START_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && !ram_we_o)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_ready_o |-> !ram_re_o); // R9
endmodule

// File: rtl/cmac_lane.sv
module cmac_lane
  import cmac_pkg::*;
#(
  parameter int unsigned W_W = WGT_W,
  parameter int unsigned S_W = SUM_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           acc_en_i,
  input  logic           upd_en_i,
  input  logic [W_W-1:0] rd_i,
  input  logic [W_W-1:0] adj_i,
  output logic [S_W-1:0] sum_o,
  output logic [W_W-1:0] wdata_o
);
  localparam logic [S_W-1:0] S_MAX = {1'b0, {(S_W-1){1'b1}}};
  localparam logic [S_W-1:0] S_MIN = {1'b1, {(S_W-1){1'b0}}};
  localparam logic [W_W-1:0] W_MAX = {1'b0, {(W_W-1){1'b1}}};
  localparam logic [W_W-1:0] W_MIN = {1'b1, {(W_W-1){1'b0}}};

  logic [S_W-1:0] sum_q, sum_nxt;
  logic [W_W-1:0] wdat_q, wdat_nxt;
  logic [S_W:0]   s_ext;
  logic [W_W:0]   w_ext;

  // one guard bit: overflow when the two top bits disagree
  always_comb begin
    s_ext = {sum_q[S_W-1], sum_q} + {{(S_W+1-W_W){rd_i[W_W-1]}}, rd_i};
    if (s_ext[S_W] != s_ext[S_W-1]) sum_nxt = s_ext[S_W] ? S_MIN : S_MAX;
    else                            sum_nxt = s_ext[S_W-1:0];
    w_ext = {rd_i[W_W-1], rd_i} + {adj_i[W_W-1], adj_i};
    if (w_ext[W_W] != w_ext[W_W-1]) wdat_nxt = w_ext[W_W] ? W_MIN : W_MAX;
    else                            wdat_nxt = w_ext[W_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      wdat_q <= '0;
    end else begin
      if (clr_i)         sum_q <= '0;
      else if (acc_en_i) sum_q <= sum_nxt;
      if (upd_en_i)      wdat_q <= wdat_nxt;
    end
  end

  assign sum_o   = sum_q;
  assign wdata_o = wdat_q;

  AST_SUM_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && !clr_i && !rd_i[W_W-1]) |=> ($signed(sum_q) >= $signed($past(sum_q)))); // R4
  AST_SUM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_en_i && !clr_i) |=> $stable(sum_q)); // R7
endmodule

// File: rtl/cmac_accum.sv
module cmac_accum
  import cmac_pkg::*;
#(
  parameter int unsigned N_CH = CH_N,
  parameter int unsigned W_W  = WGT_W,
  parameter int unsigned S_W  = SUM_W,
  parameter int unsigned A_W  = ADR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                train_i,
  input  logic [N_CH*W_W-1:0] adj_i,
  input  logic                addr_valid_i,
  input  logic [A_W-1:0]      addr_i,
  input  logic                last_i,
  output logic                addr_ready_o,
  output logic                ram_re_o,
  output logic                ram_we_o,
  output logic [A_W-1:0]      ram_addr_o,
  output logic [N_CH*W_W-1:0] ram_wdata_o,
  input  logic [N_CH*W_W-1:0] ram_rdata_i,
  output logic [N_CH*S_W-1:0] sum_o,
  output logic                done_o
);
  logic clr, acc_en, upd_en;

  cmac_ctrl #(.A_W(A_W)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .train_i      (train_i),
    .addr_valid_i (addr_valid_i),
    .addr_i       (addr_i),
    .last_i       (last_i),
    .addr_ready_o (addr_ready_o),
    .ram_re_o     (ram_re_o),
    .ram_we_o     (ram_we_o),
    .ram_addr_o   (ram_addr_o),
    .done_o       (done_o),
    .clr_o        (clr),
    .acc_en_o     (acc_en),
    .upd_en_o     (upd_en)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_lane
    cmac_lane #(.W_W(W_W), .S_W(S_W)) i_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr),
      .acc_en_i (acc_en),
      .upd_en_i (upd_en),
      .rd_i     (ram_rdata_i[k*W_W +: W_W]),
      .adj_i    (adj_i[k*W_W +: W_W]),
      .sum_o    (sum_o[k*S_W +: S_W]),
      .wdata_o  (ram_wdata_o[k*W_W +: W_W])
    );
  end
endmodule

// File: tb/test_cmac_accum.sv
module test_cmac_accum;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, train_i = 1'b0;
  logic [63:0] adj_i = '0;
  logic        addr_valid_i = 1'b0, last_i = 1'b0;
  logic [17:0] addr_i = '0;
  logic        addr_ready_o, ram_re_o, ram_we_o, done_o;
  logic [17:0] ram_addr_o;
  logic [63:0] ram_wdata_o, ram_rdata_i;
  logic [127:0] sum_o;

  int total = 0, bad = 0;
  bit run_chk = 1'b0;
  logic [63:0] mem [int];

  always #5 clk = ~clk;

  cmac_accum i_cmac_accum (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .train_i(train_i),
    .adj_i(adj_i), .addr_valid_i(addr_valid_i), .addr_i(addr_i), .last_i(last_i),
    .addr_ready_o(addr_ready_o), .ram_re_o(ram_re_o), .ram_we_o(ram_we_o),
    .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i),
    .sum_o(sum_o), .done_o(done_o)
  );

  function automatic logic [63:0] rd(input int a);
    if (mem.exists(a)) return mem[a];
    return '0;
  endfunction
  function automatic int lane8(input logic [63:0] w, input int k);
    return int'($signed(w[8*k +: 8]));
  endfunction
  function automatic int lane16(input logic [127:0] w, input int k);
    return int'($signed(w[16*k +: 16]));
  endfunction
  function automatic int clip(input int v, input int lo, input int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  // weight RAM, one cycle read latency
  initial ram_rdata_i = '0;
  always @(posedge clk) begin
    if (ram_re_o) ram_rdata_i <= rd(int'(ram_addr_o));
    if (ram_we_o) mem[int'(ram_addr_o)] = ram_wdata_o;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int    ms [8];
  bit    m_act, m_mode, m_done, r_pend, r_last, t_last;
  int    t_stage;
  logic [63:0] r_data, t_rd, t_new;
  logic [17:0] t_addr;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (ms[k]) ms[k] = 0;
      m_act = 0; m_mode = 0; m_done = 0; r_pend = 0; t_stage = 0;
    end else begin
      bit acc;
      acc = addr_valid_i && m_act && !(m_mode && t_stage != 0) && !start_i;
      if (start_i) begin
        foreach (ms[k]) ms[k] = 0;
        m_act = 1; m_mode = train_i; m_done = 0; r_pend = 0; t_stage = 0;
      end else begin
        if (r_pend) begin
          for (int k = 0; k < 8; k++) ms[k] = clip(ms[k] + lane8(r_data, k), -32768, 32767);
          if (r_last) m_done = 1;
          r_pend = 0;
        end
        if (t_stage == 2) begin
          if (t_last) m_done = 1;
          t_stage = 0;
        end else if (t_stage == 1) begin
          for (int k = 0; k < 8; k++)
            t_new[8*k +: 8] = 8'(clip(lane8(t_rd, k) + lane8(adj_i, k), -128, 127));
          t_stage = 2;
        end
        if (acc) begin
          if (m_mode) begin
            t_stage = 1; t_addr = addr_i; t_last = last_i; t_rd = rd(int'(addr_i));
          end else begin
            r_pend = 1; r_last = last_i; r_data = rd(int'(addr_i));
          end
          if (last_i) m_act = 0;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (run_chk && rst_ni) begin
      bit e_rdy, e_re, e_we;
      e_rdy = m_act && !(m_mode && t_stage != 0) && !start_i;
      e_re  = e_rdy && addr_valid_i;
      e_we  = (t_stage == 2);
      chk(addr_ready_o == e_rdy, "R7", 64'(addr_ready_o), 64'(e_rdy));
      chk(ram_re_o == e_re, "R3", 64'(ram_re_o), 64'(e_re));
      chk(ram_we_o == e_we, "R5", 64'(ram_we_o), 64'(e_we));
      chk(!(ram_re_o && ram_we_o), "R10", 64'(ram_we_o), 64'(0));
      if (e_re) chk(ram_addr_o == addr_i, "R3", 64'(ram_addr_o), 64'(addr_i));
      if (e_we) begin
        chk(ram_addr_o == t_addr, "R5", 64'(ram_addr_o), 64'(t_addr));
        chk(ram_wdata_o == t_new, "R5", ram_wdata_o, t_new);
      end
      for (int k = 0; k < 8; k++)
        chk(lane16(sum_o, k) == ms[k], "R3", 64'(lane16(sum_o, k)), 64'(ms[k]));
      chk(done_o == m_done, "R8", 64'(done_o), 64'(m_done));
    end
  end

  task automatic pulse_start(input bit tr);
    @(negedge clk); start_i = 1; train_i = tr;
    @(negedge clk); start_i = 0;
  endtask
  task automatic send(input int a, input bit l);
    @(negedge clk); addr_valid_i = 1; addr_i = 18'(a); last_i = l;
    #1;
    while (!addr_ready_o) begin @(negedge clk); #1; end
  endtask
  task automatic idle(input int n);
    @(negedge clk); addr_valid_i = 0; last_i = 0;
    repeat (n) @(negedge clk);
  endtask
  task automatic wait_done();
    int g = 0;
    while (!done_o && g < 100) begin @(negedge clk); g++; end
  endtask
  function automatic logic [63:0] mk(input int s);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[8*k +: 8] = 8'((s * 29 + k * 53) % 256);
    return w;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 1; a <= 8; a++) mem[a] = mk(a);
    repeat (3) @(negedge clk);
    #1;
    // R1 during and after reset
    chk(sum_o == '0 && !done_o && !addr_ready_o && !ram_re_o && !ram_we_o, "R1", 64'(done_o), 64'(0));
    rst_ni = 1;
    run_chk = 1;
    @(negedge clk); #1;
    chk(sum_o == '0 && !done_o && !addr_ready_o, "R1", 64'(addr_ready_o), 64'(0));
    // R9 address before start
    @(negedge clk); addr_valid_i = 1; addr_i = 18'd3;
    repeat (3) begin @(negedge clk); #1; chk(!ram_re_o, "R9", 64'(ram_re_o), 64'(0)); end
    addr_valid_i = 0;

    // recall, back to back
    pulse_start(0);
    for (int a = 1; a <= 4; a++) send(a, a == 4);
    idle(0);
    wait_done();
    begin
      int e0 = 0;
      for (int a = 1; a <= 4; a++) e0 += lane8(mem[a], 0);
      chk(lane16(sum_o, 0) == e0, "R3", 64'(lane16(sum_o, 0)), 64'(e0));
    end
    // R9 after last: no access
    @(negedge clk); addr_valid_i = 1; addr_i = 18'd2;
    repeat (3) begin @(negedge clk); #1; chk(!ram_re_o, "R9", 64'(ram_re_o), 64'(0)); end
    chk(done_o, "R8", 64'(done_o), 64'(1));
    addr_valid_i = 0;

    // recall with gaps, repeated address
    pulse_start(0);
    #1; chk(sum_o == '0 && !done_o, "R2", 64'(done_o), 64'(0));
    send(5, 0); idle(2); send(6, 0); idle(1); send(5, 0); send(8, 1); idle(0);
    wait_done();

    // saturation of sums
    mem[10] = {8'd1, 8'd0, 8'hFF, 8'd100, 8'hF6, 8'd50, 8'h80, 8'd127};
    pulse_start(0);
    for (int i = 0; i < 300; i++) send(10, i == 299);
    idle(0);
    wait_done();
    chk(lane16(sum_o, 0) == 32767, "R4", 64'(lane16(sum_o, 0)), 64'(32767));
    chk(lane16(sum_o, 1) == -32768, "R4", 64'(lane16(sum_o, 1)), 64'(-32768));

    // training with weight saturation and a repeated address
    mem[20] = {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd5, 8'h88, 8'd120};
    mem[21] = mk(21);
    adj_i = {8'd0, 8'd0, 8'd0, 8'd0, 8'hFF, 8'd3, 8'hEC, 8'd20};
    pulse_start(1);
    send(20, 0); send(21, 0); send(20, 1); idle(0);
    wait_done();
    chk(lane8(mem[20], 0) == 127, "R6", 64'(lane8(mem[20], 0)), 64'(127));
    chk(lane8(mem[20], 1) == -128, "R6", 64'(lane8(mem[20], 1)), 64'(-128));
    chk(lane8(mem[20], 2) == 11, "R5", 64'(lane8(mem[20], 2)), 64'(11));
    chk(sum_o == '0, "R7", sum_o[63:0], 64'(0));

    // start during training read: write dropped
    mem[30] = mk(30);
    pulse_start(1);
    send(30, 1);
    @(negedge clk); addr_valid_i = 0; last_i = 0; start_i = 1; train_i = 0;
    @(negedge clk); start_i = 0;
    repeat (4) @(negedge clk);
    chk(mem[30] == mk(30), "R2", mem[30], mk(30));

    // recall of trained words seen at the ports
    adj_i = '0;
    pulse_start(0);
    send(20, 0); send(21, 1); idle(0);
    wait_done();
    chk(done_o, "R8", 64'(done_o), 64'(1));

    run_chk = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule